// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block steps a processor's bus through the clock states of each machine cycle when the low address byte and the data byte share one set of pins. The core hands it one cycle request at a time: a kind code, a 16-bit address, a write byte and, for an opcode fetch, a choice of a 4-state or 6-state fetch. The block drives the upper address byte, the shared low byte, an address latch strobe, three status lines and active-low read, write and interrupt-acknowledge strobes. It pulses `done` back to the core in the last state of the cycle.

A slow device stretches a transfer by holding `ready_in` low, which adds whole-clock wait states. Another bus master can ask for the bus through `hold_in`. The block finishes the transfer in progress, then acknowledges and releases the bus. Pins that would be three-stated on a real bus are modelled as data outputs with separate output-enable signals.

Top module: `mxbus_sequencer`

## Requirements
- R1: In the first state of a cycle (T1), `ale` is 1, `ad_out` carries the low address byte with `ad_oe`=1, and `a_hi` carries the high byte with `a_hi_oe`=1. `ale` is 1 in no other state.
- R2: During a cycle, {`io_m`,`s1`,`s0`} depends on `req_kind` as follows:
  - 0 (opcode fetch): 011
  - 1 (memory read): 010
  - 2 (memory write): 001
  - 3 (I/O read): 110
  - 4 (I/O write): 101
  - 5 (interrupt acknowledge): 111
- R3: The status lines hold the same value in every state from T1 to the last state of a cycle.
- R4: A non-fetch cycle is T1,T2,T3. A fetch with `req_long` low adds T4, and a fetch with `req_long` high adds T4,T5,T6. Wait states add to these lengths. `done` is 1 only in the last state.
- R5: `ready_in` is sampled at the end of T2 and at the end of every wait state. While it is low, another wait state follows and the active strobe stays asserted.
- R6: Strobes are active in T2 and in wait states, and inactive from T3 on:
  - Reads (kinds 0, 1, 3) drive `rd_n` low.
  - Writes (kinds 2, 4) drive `wr_n` low and hold the write byte on `ad_out` with `ad_oe`=1 through T3.
  - Kind 5 drives `inta_n` low in place of `rd_n`.
  - `rd_data` returns the `ad_in` value sampled at the clock edge where ready is seen high.
- R7: For I/O cycles (kinds 3, 4), the port number `req_addr[7:0]` appears on both `a_hi` and the low byte in T1.
- R8: If `hold_in` is 1 when a cycle ends, the cycle still completes with its normal length. `hlda` then rises one clock later. While `hlda` is 1:
  - `ale` is 0, and `a_hi_oe`, `ad_oe`, `ctl_oe` and `io_m_oe` are all 0.
  - `req_take` is 0.
  - After `hold_in` falls, `hlda` falls at the next clock, and requests are accepted again after that.
- R9: Kind 6 or 7 is a halt. It puts the block in a halt state with all address, data, control and `io_m` enables at 0, `s1`=`s0`=0 and `ale`=0. The halt state lasts until a new request is accepted, and it produces no `done`.
- R10: While `rst_n` is 0, all output enables are 0, and `ale`, `hlda` and `done` are 0.
- R11: `req_take` is 1, and a request with `req_valid`=1 is accepted, only when `hold_in` is 0 and the block is idle, halted or in the last state of a cycle. An accepted cycle starts T1 at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core offers a cycle request |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Memory address, or port number in bits 7:0 |
| req_wdata | input | 8 | Byte to write |
| req_long | input | 1 | Fetch uses six states instead of four |
| req_take | output | 1 | A request offered now would be accepted |
| done | output | 1 | Last state of the current cycle |
| rd_data | output | 8 | Byte captured by the last read |
| ready_in | input | 1 | Device ready; low inserts wait states |
| hold_in | input | 1 | External master requests the bus |
| hlda | output | 1 | Bus released to the external master |
| a_hi | output | 8 | Upper address byte |
| a_hi_oe | output | 1 | Enable for `a_hi` |
| ad_out | output | 8 | Shared low address / data byte, outgoing |
| ad_oe | output | 1 | Enable for `ad_out` |
| ad_in | input | 8 | Shared low byte, incoming |
| ale | output | 1 | Address latch strobe, never floated |
| io_m | output | 1 | Status: I/O (1) or memory (0) |
| io_m_oe | output | 1 | Enable for `io_m` |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| ctl_oe | output | 1 | Enable for `rd_n`, `wr_n`, `inta_n` |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt-acknowledge strobe, active low |

## Verification
The bench checks the number of wait states against the number of cycles it keeps `ready_in` low. A sequencer that sampled ready one state late, or ignored it, would give a cycle of the wrong length or drop its strobe while ready is still low. It issues I/O cycles with a distinctive port number and no high-byte bits set, so a design that failed to copy the port number would show a zero upper byte. It raises hold in the middle of a write to catch a design that abandons the transfer or grants the bus early. It also checks that a request offered during hold is refused. Short and long fetches, and an acknowledge cycle where `inta_n` must replace `rd_n`, catch wrong state counts and wrong strobe choice.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int HI_W   = ADDR_W - DATA_W;

    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_MEMRD = 3'd1,
        K_MEMWR = 3'd2,
        K_IORD  = 3'd3,
        K_IOWR  = 3'd4,
        K_INTA  = 3'd5,
        K_HALT  = 3'd6,
        K_RSVD  = 3'd7
    } kind_e;

    typedef enum logic [3:0] {
        PH_IDLE, PH_T1, PH_T2, PH_TW, PH_T3,
        PH_T4, PH_T5, PH_T6, PH_HALT, PH_HOLD
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [2:0]          kind;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic                long_fetch;
        logic [DATA_W-1:0]   rdata;
    } seq_s;

    function automatic logic kind_is_halt(input logic [2:0] k);
        return (k == K_HALT) || (k == K_RSVD);
    endfunction
endpackage

// File: rtl/mxbus_status_enc.sv
module mxbus_status_enc
    import mxbus_pkg::*;
(
    input  logic [2:0] kind,
    output logic       io_m,
    output logic       s1,
    output logic       s0,
    output logic       is_fetch,
    output logic       is_rd,
    output logic       is_wr,
    output logic       is_inta,
    output logic       is_io
);
    always_comb begin
        {io_m, s1, s0} = 3'b000;
        is_fetch = 1'b0;
        is_rd    = 1'b0;
        is_wr    = 1'b0;
        is_inta  = 1'b0;
        is_io    = 1'b0;
        case (kind)
            K_FETCH: begin {io_m, s1, s0} = 3'b011; is_fetch = 1'b1; is_rd = 1'b1; end
            K_MEMRD: begin {io_m, s1, s0} = 3'b010; is_rd = 1'b1; end
            K_MEMWR: begin {io_m, s1, s0} = 3'b001; is_wr = 1'b1; end
            K_IORD:  begin {io_m, s1, s0} = 3'b110; is_rd = 1'b1; is_io = 1'b1; end
            K_IOWR:  begin {io_m, s1, s0} = 3'b101; is_wr = 1'b1; is_io = 1'b1; end
            K_INTA:  begin {io_m, s1, s0} = 3'b111; is_inta = 1'b1; end
            default: {io_m, s1, s0} = 3'b000;
        endcase
    end
endmodule

// File: rtl/mxbus_addr_place.sv
module mxbus_addr_place
    import mxbus_pkg::*;
#(
    parameter bit DUP_IO = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_io,
    output logic [HI_W-1:0]   hi,
    output logic [DATA_W-1:0] lo
);
    assign lo = addr[DATA_W-1:0];
    generate
        if (DUP_IO) begin : g_dup
            assign hi = is_io ? addr[HI_W-1:0] : addr[ADDR_W-1:DATA_W];
        end else begin : g_plain
            logic unused_io;
            assign unused_io = is_io;
            assign hi = addr[ADDR_W-1:DATA_W];
        end
    endgenerate
endmodule

// File: rtl/mxbus_sequencer.sv
module mxbus_sequencer
    import mxbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_long,
    output logic              req_take,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ready_in,
    input  logic              hold_in,
    output logic              hlda,
    output logic [HI_W-1:0]   a_hi,
    output logic              a_hi_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ale,
    output logic              io_m,
    output logic              io_m_oe,
    output logic              s1,
    output logic              s0,
    output logic              ctl_oe,
    output logic              rd_n,
    output logic              wr_n,
    output logic              inta_n
);
    seq_s q, d;

    logic enc_io_m, enc_s1, enc_s0;
    logic is_fetch, is_rd, is_wr, is_inta, is_io;
    logic [HI_W-1:0]   hi_byte;
    logic [DATA_W-1:0] lo_byte;

    mxbus_status_enc enc_i (
        .kind(q.kind), .io_m(enc_io_m), .s1(enc_s1), .s0(enc_s0),
        .is_fetch(is_fetch), .is_rd(is_rd), .is_wr(is_wr),
        .is_inta(is_inta), .is_io(is_io)
    );

    mxbus_addr_place #(.DUP_IO(1'b1)) place_i (
        .addr(q.addr), .is_io(is_io), .hi(hi_byte), .lo(lo_byte)
    );

    logic final_st, in_cycle, strobe_st, take;

    assign final_st = (q.phase == PH_T3 && !is_fetch)
                   || (q.phase == PH_T4 && is_fetch && !q.long_fetch)
                   || (q.phase == PH_T6);
    assign in_cycle = q.phase inside {PH_T1, PH_T2, PH_TW, PH_T3, PH_T4, PH_T5, PH_T6};
    assign strobe_st = (q.phase == PH_T2) || (q.phase == PH_TW);
    assign req_take = !hold_in && (q.phase == PH_IDLE || q.phase == PH_HALT || final_st);
    assign take = req_take && req_valid;

    always_comb begin
        d = q;
        case (q.phase)
            PH_T1:        d.phase = PH_T2;
            PH_T2, PH_TW: begin
                if (ready_in) begin
                    d.phase = PH_T3;
                    if (!is_wr) d.rdata = ad_in;
                end else begin
                    d.phase = PH_TW;
                end
            end
            PH_T3:        d.phase = PH_T4;
            PH_T4:        d.phase = PH_T5;
            PH_T5:        d.phase = PH_T6;
            PH_HOLD:      if (!hold_in) d.phase = PH_IDLE;
            default:      d.phase = q.phase;
        endcase
        if (q.phase == PH_IDLE || q.phase == PH_HALT || final_st) begin
            if (take) begin
                d.kind       = req_kind;
                d.addr       = req_addr;
                d.wdata      = req_wdata;
                d.long_fetch = req_long;
                d.phase      = kind_is_halt(req_kind) ? PH_HALT : PH_T1;
            end else if (hold_in) begin
                d.phase = PH_HOLD;
            end else if (final_st) begin
                d.phase = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign ale     = rst_n && (q.phase == PH_T1);
    assign a_hi    = hi_byte;
    assign a_hi_oe = rst_n && in_cycle;
    assign ad_out  = (q.phase == PH_T1) ? lo_byte : q.wdata;
    assign ad_oe   = rst_n && ((q.phase == PH_T1)
                   || (is_wr && (strobe_st || q.phase == PH_T3)));
    assign io_m    = enc_io_m;
    assign io_m_oe = rst_n && in_cycle;
    assign s1      = in_cycle ? enc_s1 : 1'b0;
    assign s0      = in_cycle ? enc_s0 : 1'b0;
    assign ctl_oe  = rst_n && !(q.phase == PH_HALT || q.phase == PH_HOLD);
    assign rd_n    = !(strobe_st && is_rd);
    assign wr_n    = !(strobe_st && is_wr);
    assign inta_n  = !(strobe_st && is_inta);
    assign hlda    = rst_n && (q.phase == PH_HOLD);
    assign done    = rst_n && final_st;
    assign rd_data = q.rdata;

    AST_STATUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_m_oe && !ale && $past(io_m_oe)) |-> $stable({io_m, s1, s0})); // R3
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~rd_n, ~wr_n, ~inta_n})); // R6
    AST_WAIT_HOLDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rd_n && wr_n && inta_n) && !ready_in) |=> (!(rd_n && wr_n && inta_n)
            && $stable({rd_n, wr_n, inta_n}))); // R5
    AST_IO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && io_m && !(s1 && s0)) |-> (a_hi == ad_out)); // R7
    AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!a_hi_oe && !ad_oe && !ctl_oe && !io_m_oe && !ale && !req_take)); // R8
    AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hold_in) |=> hlda); // R8
    AST_ALE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && a_hi_oe && !done)); // R1
endmodule

// File: tb/mxbus_sequencer_tb.sv
module mxbus_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0] req_wdata = 8'h0;
    logic req_long = 1'b0;
    logic req_take, done, hlda, a_hi_oe, ad_oe, ale, io_m, io_m_oe, s1, s0;
    logic ctl_oe, rd_n, wr_n, inta_n;
    logic [7:0] rd_data, a_hi, ad_out;
    logic ready_in = 1'b1;
    logic hold_in = 1'b0;
    logic [7:0] ad_in = 8'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mxbus_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_long(req_long),
        .req_take(req_take), .done(done), .rd_data(rd_data), .ready_in(ready_in),
        .hold_in(hold_in), .hlda(hlda), .a_hi(a_hi), .a_hi_oe(a_hi_oe),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .io_m(io_m),
        .io_m_oe(io_m_oe), .s1(s1), .s0(s0), .ctl_oe(ctl_oe), .rd_n(rd_n),
        .wr_n(wr_n), .inta_n(inta_n)
    );

    typedef struct {
        logic [2:0]  kind;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic        lng;
        int          waits;
        logic [7:0]  rdin;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int waits_left = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    function automatic logic [2:0] exp_status(input logic [2:0] k);
        case (k)
            3'd0: return 3'b011;
            3'd1: return 3'b010;
            3'd2: return 3'b001;
            3'd3: return 3'b110;
            3'd4: return 3'b101;
            3'd5: return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    // ready driver: hold ready low for the requested number of strobe states
    initial begin
        forever begin
            @(negedge clk);
            if (!(rd_n && wr_n && inta_n) && waits_left > 0) begin
                ready_in = 1'b0;
                waits_left--;
            end else begin
                ready_in = 1'b1;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        exp_t cur;
        int cnt = 0;
        bit active = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (ale) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R11 unexpected cycle", 32'(ale), 0);
                    end else begin
                        logic [7:0] ehi;
                        cur = exp_q.pop_front();
                        active = 1;
                        cnt = 1;
                        ehi = (cur.kind == 3'd3 || cur.kind == 3'd4) ? cur.addr[7:0] : cur.addr[15:8];
                        chk(a_hi == ehi && a_hi_oe, (cur.kind == 3'd3 || cur.kind == 3'd4) ? "R7 port on high byte" : "R1 high address", 32'(a_hi), 32'(ehi));
                        chk(ad_out == cur.addr[7:0] && ad_oe, "R1 low address in T1", 32'(ad_out), 32'(cur.addr[7:0]));
                        chk({io_m, s1, s0} == exp_status(cur.kind) && io_m_oe, "R2 status code", 32'({io_m, s1, s0}), 32'(exp_status(cur.kind)));
                    end
                end else if (active) begin
                    cnt++;
                    chk({io_m, s1, s0} == exp_status(cur.kind), "R3 status stable", 32'({io_m, s1, s0}), 32'(exp_status(cur.kind)));
                    chk(!ale, "R1 ale only in T1", 32'(ale), 0);
                    if (cnt == 2) begin
                        logic [2:0] es;
                        es = (cur.kind == 3'd2 || cur.kind == 3'd4) ? 3'b101 :
                             (cur.kind == 3'd5) ? 3'b110 : 3'b011;
                        chk({rd_n, wr_n, inta_n} == es, "R6 strobe in T2", 32'({rd_n, wr_n, inta_n}), 32'(es));
                        if (cur.kind == 3'd2 || cur.kind == 3'd4)
                            chk(ad_out == cur.wdata && ad_oe, "R6 write data in T2", 32'(ad_out), 32'(cur.wdata));
                    end
                    if (done) begin
                        int elen;
                        elen = 3 + cur.waits + ((cur.kind == 3'd0) ? (cur.lng ? 3 : 1) : 0);
                        chk(cnt == elen, cur.waits > 0 ? "R5 wait states length" : "R4 cycle length", 32'(cnt), 32'(elen));
                        chk({rd_n, wr_n, inta_n} == 3'b111, "R6 strobes inactive at end", 32'({rd_n, wr_n, inta_n}), 32'h7);
                        if (cur.kind == 3'd2 || cur.kind == 3'd4)
                            chk(ad_out == cur.wdata && ad_oe, "R6 write data held in T3", 32'(ad_out), 32'(cur.wdata));
                        else
                            chk(rd_data == cur.rdin, "R6 read data captured", 32'(rd_data), 32'(cur.rdin));
                        active = 0;
                    end
                end else if (done) begin
                    chk(0, "R4 done outside cycle", 32'(done), 0);
                end
            end
        end
    end

    task automatic issue(input logic [2:0] kind, input logic [15:0] addr,
                         input logic [7:0] wd, input logic lng, input int waits,
                         input logic [7:0] rdin);
        exp_t e;
        @(negedge clk);
        e.kind = kind; e.addr = addr; e.wdata = wd; e.lng = lng;
        e.waits = waits; e.rdin = rdin;
        exp_q.push_back(e);
        req_kind = kind; req_addr = addr; req_wdata = wd; req_long = lng;
        ad_in = rdin; waits_left = waits;
        req_valid = 1'b1;
        chk(req_take == 1'b1, "R11 take when idle", 32'(req_take), 1);
        @(negedge clk);
        req_valid = 1'b0;
        while (done !== 1'b1) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk({a_hi_oe, ad_oe, io_m_oe, ctl_oe} == 4'b0, "R10 enables off in reset",
            32'({a_hi_oe, ad_oe, io_m_oe, ctl_oe}), 0);
        chk({ale, hlda, done} == 3'b0, "R10 ale/hlda/done low in reset", 32'({ale, hlda, done}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        issue(3'd0, 16'h1234, 8'h00, 1'b0, 0, 8'hA5); // R4 short fetch
        issue(3'd0, 16'h2345, 8'h00, 1'b1, 0, 8'h5A); // R4 long fetch
        issue(3'd1, 16'hBEEF, 8'h00, 1'b0, 2, 8'h3C); // R5 read with waits
        issue(3'd2, 16'hC0DE, 8'h77, 1'b0, 0, 8'h00); // R6 write
        issue(3'd2, 16'h4455, 8'h99, 1'b0, 3, 8'h00); // R5 write with waits
        issue(3'd3, 16'h0042, 8'h00, 1'b0, 0, 8'h81); // R7 I/O read
        issue(3'd4, 16'h00C3, 8'h6E, 1'b0, 1, 8'h00); // R7 I/O write
        issue(3'd5, 16'h0000, 8'h00, 1'b0, 0, 8'hFF); // R6 acknowledge
        issue(3'd0, 16'hFFFE, 8'h00, 1'b1, 1, 8'h11); // R4 long fetch with wait

        // R9 halt
        @(negedge clk);
        req_kind = 3'd6; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk({a_hi_oe, ad_oe, io_m_oe, ctl_oe, ale} == 5'b0, "R9 halt floats bus",
                32'({a_hi_oe, ad_oe, io_m_oe, ctl_oe, ale}), 0);
            chk({s1, s0, done} == 3'b0, "R9 halt status zero", 32'({s1, s0, done}), 0);
            chk(req_take == 1'b1, "R11 take while halted", 32'(req_take), 1);
            @(negedge clk);
        end
        issue(3'd1, 16'h0F0F, 8'h00, 1'b0, 0, 8'h2D); // leaves halt

        // R8 hold raised during a write
        fork
            issue(3'd2, 16'h8001, 8'hB4, 1'b0, 1, 8'h00);
            begin
                @(negedge clk);
                @(negedge clk);
                hold_in = 1'b1;
            end
        join
        @(negedge clk);
        chk(hlda == 1'b1, "R8 hlda after cycle", 32'(hlda), 1);
        chk({a_hi_oe, ad_oe, io_m_oe, ctl_oe, ale} == 5'b0, "R8 bus floated in hold",
            32'({a_hi_oe, ad_oe, io_m_oe, ctl_oe, ale}), 0);
        req_kind = 3'd1; req_addr = 16'h1111; req_valid = 1'b1;
        chk(req_take == 1'b0, "R8 no take in hold", 32'(req_take), 0);
        @(negedge clk);
        chk(hlda == 1'b1 && !ale && !a_hi_oe, "R8 request ignored in hold", 32'({hlda, ale, a_hi_oe}), 32'h4);
        req_valid = 1'b0;
        hold_in = 1'b0;
        @(negedge clk);
        chk(hlda == 1'b0, "R8 hlda drops after hold", 32'(hlda), 0);
        issue(3'd1, 16'h1111, 8'h00, 1'b0, 0, 8'h4B); // R8 bus retaken

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all cycles seen", 32'(exp_q.size()), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule